// File: doc/BRIEF.md
# Runtime Bitfield Extract and Insert Unit

This block manipulates an arbitrary run of bits inside 32-bit words, with both the field position (offset) and the field length (width) supplied as runtime operands on every operation. It has three operations. Zero-extending extract moves a field down to bit 0 and clears everything above it. Sign-extending extract does the same, then fills the upper bits with copies of the field's most significant bit. Masked insert overwrites a field of a base word with the low bits of a second word.

A parameter sets how many lanes run side by side. All lanes share the opcode, offset and width. Each lane has its own value word and insert word, and produces its own result. A second parameter chooses between a registered output stage and a purely combinational path. The field logic is written once and instanced per lane. A single mask generator serves every lane, because the field geometry is the same for all lanes.

Top module: `bitfield_unit`

## Requirements
- R1: Opcode 2'b00 (zero-extending extract) returns `value >> offset` with every bit at or above the effective width cleared.
- R2: Opcode 2'b01 (sign-extending extract) returns the same field as R1. Every bit at or above the effective width is a copy of the field's top bit.
- R3: A sign-extending extract with width 1 returns 32'hFFFFFFFF when the selected bit is 1, and 32'h00000000 when it is 0.
- R4: Opcode 2'b10 (insert) replaces bits [offset +: effective width] of the value word with the low bits of the insert word. All other bits of the value word are kept.
- R5: Insert ignores every bit of the insert word at or above the effective width; they never reach the result.
- R6: A width of 0 makes both extracts return 0 and makes insert return the value word unchanged.
- R7: When offset + width exceeds 32, the effective width is 32 − offset, so the field ends at bit 31. A sign-extending extract then uses bit 31 as its sign.
- R8: Widths of 32 to 63 are treated as 32. A width of 32 at offset 0 returns the whole value word for both extracts, and returns the whole insert word for insert.
- R9: Opcode 2'b11 is reserved and returns the value word unchanged.
- R10: Each lane's result depends only on that lane's value and insert words.
- R11: With the registered output, `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. The result is captured on that same edge.
- R12: While reset is high, `out_valid` and every result bit are driven to 0 in the registered configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| opcode | input | 2 | 00 zero-extract, 01 sign-extract, 10 insert, 11 reserved |
| offset | input | 5 | Field start bit |
| width | input | 6 | Field length, 0 to 63 |
| value_i | input | LANES*32 | Value or base word per lane, lane 0 in the low bits |
| insert_i | input | LANES*32 | Insert word per lane |
| out_valid | output | 1 | Result strobe |
| result_o | output | LANES*32 | Result per lane |

## Verification
The hardest case to reach is a field that runs off the top of the word with a sign bit that differs from its neighbours. The truncated width then places the sign at bit 31, not at offset + width − 1, so a wrong sign tap only shows up for particular offset/width pairs with particular data. The bench sweeps every opcode against every offset and every width from 0 to 63. Each lane gets fresh pseudo-random data for every vector, so every truncated geometry is seen with both sign polarities. Directed vectors cover one-bit sign fills and an all-ones insert word.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 5;
  localparam int WID_W  = 6;

  typedef enum logic [1:0] {
    OP_UEXT = 2'b00,
    OP_SEXT = 2'b01,
    OP_INS  = 2'b10,
    OP_RSVD = 2'b11
  } bfu_op_e;
endpackage

// File: rtl/bfu_mask_gen.sv
module bfu_mask_gen #(
  parameter int DATA_W = bfu_pkg::DATA_W,
  parameter int OFF_W  = bfu_pkg::OFF_W,
  parameter int WID_W  = bfu_pkg::WID_W,
  localparam int EW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  offset,
  input  logic [WID_W-1:0]  width,
  output logic [EW-1:0]     eff_width,
  output logic [DATA_W-1:0] low_mask,
  output logic [DATA_W-1:0] place_mask,
  output logic [DATA_W-1:0] top_mask
);
  // Clamp the requested width to the word and to the room above the offset.
  always_comb begin
    int w_i;
    int room_i;
    w_i    = int'(width);
    room_i = DATA_W - int'(offset);
    if (w_i > DATA_W) w_i = DATA_W;
    if (w_i > room_i) w_i = room_i;
    eff_width = EW'(w_i);
  end

  // Thermometer mask of the low eff_width bits.
  for (genvar g = 0; g < DATA_W; g++) begin : g_low
    assign low_mask[g] = (int'(eff_width) > g);
  end

  assign place_mask = low_mask << offset;
  assign top_mask   = low_mask & ~(low_mask >> 1);

  // R7: the placed field never wraps, so every effective bit survives the shift
  a_r7_field_fits: assert property (@(posedge clk) disable iff (rst)
    $countones(place_mask) == int'(eff_width));
  // R8: an oversized width at offset 0 covers the full word
  a_r8_full_word: assert property (@(posedge clk) disable iff (rst)
    (int'(width) >= DATA_W && offset == '0) |-> (&low_mask));
  // R2: the sign tap is one bit at most
  a_r2_single_tap: assert property (@(posedge clk) disable iff (rst)
    $onehot0(top_mask));
endmodule

// File: rtl/bfu_lane.sv
module bfu_lane
  import bfu_pkg::*;
#(
  parameter int DATA_W = bfu_pkg::DATA_W,
  parameter int OFF_W  = bfu_pkg::OFF_W,
  localparam int EW    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  bfu_op_e           op,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] ins_word,
  input  logic [EW-1:0]     eff_width,
  input  logic [DATA_W-1:0] low_mask,
  input  logic [DATA_W-1:0] place_mask,
  input  logic [DATA_W-1:0] top_mask,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] ext_zero;
  logic [DATA_W-1:0] ext_sign;
  logic [DATA_W-1:0] ins_res;
  logic              sign_bit;

  assign shifted  = value >> offset;
  assign ext_zero = shifted & low_mask;
  assign sign_bit = |(shifted & top_mask);
  assign ext_sign = ext_zero | ({DATA_W{sign_bit}} & ~low_mask);
  assign ins_res  = (value & ~place_mask) | ((ins_word << offset) & place_mask);

  always_comb begin
    unique case (op)
      OP_UEXT: result = ext_zero;
      OP_SEXT: result = ext_sign;
      OP_INS:  result = ins_res;
      default: result = value;
    endcase
  end

  // R1: nothing survives above the field on a zero-extending extract
  a_r1_zero_above: assert property (@(posedge clk) disable iff (rst)
    (op == OP_UEXT) |-> ((result & ~low_mask) == '0));
  // R2: upper bits all copy the result's own field top bit
  a_r2_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SEXT && eff_width != '0) |->
      ((result & ~low_mask) == ((|(result & top_mask)) ? ~low_mask : '0)));
  // R4: bits outside the placed field come from the value word
  a_r4_keep_outside: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INS) |-> (((result ^ value) & ~place_mask) == '0));
  // R6: empty field extracts to zero
  a_r6_empty_extract: assert property (@(posedge clk) disable iff (rst)
    (eff_width == '0 && (op == OP_UEXT || op == OP_SEXT)) |-> (result == '0));
  // R9: reserved code passes the value word
  a_r9_reserved: assert property (@(posedge clk) disable iff (rst)
    (op == OP_RSVD) |-> (result == value));
endmodule

// File: rtl/bfu_out_stage.sv
module bfu_out_stage #(
  parameter int  W       = 32,
  parameter bit  REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] d,
  output logic         out_valid,
  output logic [W-1:0] q
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        q         <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) q <= d;
      end
    end

    // R11: one-cycle strobe per accepted input
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    a_r11_valid_drops: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    // R11: the result is held between strobes
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(q));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign q         = d;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int LANES   = 2,
  parameter bit REG_OUT = 1'b1,
  localparam int DW     = bfu_pkg::DATA_W,
  localparam int OW     = bfu_pkg::OFF_W,
  localparam int WW     = bfu_pkg::WID_W,
  localparam int EW     = $clog2(DW + 1),
  localparam int BUS_W  = LANES * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       opcode,
  input  logic [OW-1:0]    offset,
  input  logic [WW-1:0]    width,
  input  logic [BUS_W-1:0] value_i,
  input  logic [BUS_W-1:0] insert_i,
  output logic             out_valid,
  output logic [BUS_W-1:0] result_o
);
  bfu_op_e        op;
  logic [EW-1:0]  eff_width;
  logic [DW-1:0]  low_mask;
  logic [DW-1:0]  place_mask;
  logic [DW-1:0]  top_mask;
  logic [BUS_W-1:0] comb_res;

  assign op = bfu_op_e'(opcode);

  bfu_mask_gen #(.DATA_W(DW), .OFF_W(OW), .WID_W(WW)) u_mask (
    .clk        (clk),
    .rst        (rst),
    .offset     (offset),
    .width      (width),
    .eff_width  (eff_width),
    .low_mask   (low_mask),
    .place_mask (place_mask),
    .top_mask   (top_mask)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    bfu_lane #(.DATA_W(DW), .OFF_W(OW)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .op         (op),
      .offset     (offset),
      .value      (value_i[l*DW +: DW]),
      .ins_word   (insert_i[l*DW +: DW]),
      .eff_width  (eff_width),
      .low_mask   (low_mask),
      .place_mask (place_mask),
      .top_mask   (top_mask),
      .result     (comb_res[l*DW +: DW])
    );
  end

  bfu_out_stage #(.W(BUS_W), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .d         (comb_res),
    .out_valid (out_valid),
    .q         (result_o)
  );

  // R12: registered outputs are cleared one edge into reset
  if (REG_OUT) begin : g_rst_chk
    a_r12_reset_clear: assert property (@(posedge clk)
      rst |=> (!out_valid && result_o == '0));
  end
endmodule

// File: tb/tb_bitfield_unit.sv
module tb_bitfield_unit;
  localparam int LANES = 2;
  localparam int DW    = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [1:0]       opcode = '0;
  logic [4:0]       offset = '0;
  logic [5:0]       width = '0;
  logic [LANES*DW-1:0] value_i = '0;
  logic [LANES*DW-1:0] insert_i = '0;
  logic             out_valid;
  logic [LANES*DW-1:0] result_o;

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;
  logic [31:0] seed = 32'h2545_F491;

  always #2 clk = ~clk;

  bitfield_unit #(.LANES(LANES), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .offset(offset), .width(width), .value_i(value_i), .insert_i(insert_i),
    .out_valid(out_valid), .result_o(result_o)
  );

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] v,
                                        input logic [31:0] ins, input int off, input int w);
    logic [31:0] r;
    int ew;
    ew = (w > 32) ? 32 : w;
    if (off + ew > 32) ew = 32 - off;
    r = v;
    if (op == 2'b00 || op == 2'b01) begin
      for (int i = 0; i < 32; i++) r[i] = (i < ew) ? v[i + off] : 1'b0;
      if (op == 2'b01 && ew > 0)
        for (int i = 0; i < 32; i++) if (i >= ew) r[i] = v[off + ew - 1];
    end else if (op == 2'b10) begin
      for (int i = 0; i < ew; i++) r[i + off] = ins[i];
    end
    return r;
  endfunction

  function automatic string tag_for(input logic [1:0] op, input int off, input int w);
    if (op == 2'b11) return "R9";
    if (w == 0) return "R6";
    if (w >= 32) return "R8";
    if (off + w > 32) return "R7";
    if (op == 2'b00) return "R1";
    if (op == 2'b01) return "R2";
    return "R4";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one operation on all lanes, check results a cycle later and the strobe drop after.
  task automatic run_vec(input logic [1:0] op, input int off, input int w,
                         input logic [LANES*DW-1:0] v, input logic [LANES*DW-1:0] ins,
                         input string tag);
    @(negedge clk);
    opcode = op; offset = 5'(off); width = 6'(w);
    value_i = v; insert_i = ins; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R11 valid high"}, {31'd0, out_valid}, 32'd1);
    for (int l = 0; l < LANES; l++)
      chk((l == 0) ? tag : {tag, " R10 lane1"}, result_o[l*DW +: DW],
          model(op, v[l*DW +: DW], ins[l*DW +: DW], off, w));
    value_i = ~v;
    @(negedge clk);
    chk({tag, " R11 valid drop"}, {31'd0, out_valid}, 32'd0);
    // R11: held result does not follow the changed inputs
    chk({tag, " R11 hold"}, result_o[31:0], model(op, v[31:0], ins[31:0], off, w));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R11 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R12 result in reset", result_o[31:0], 32'd0);
    chk("R12 result lane1 in reset", result_o[63:32], 32'd0);
    rst = 1'b0;

    // R3: one-bit sign fill, both polarities
    run_vec(2'b01, 23, 1, {32'h0080_0000, 32'h0080_0000}, '0, "R3");
    run_vec(2'b01, 23, 1, {32'hFF7F_FFFF, 32'hFF7F_FFFF}, '0, "R3");
    run_vec(2'b01, 31, 1, {32'h8000_0000, 32'h7FFF_FFFF}, '0, "R3");
    // R5: high insert bits discarded
    run_vec(2'b10, 8, 16, {32'h1234_5678, 32'h1234_5678}, {32'hFFFF_FFFF, 32'hABCD_0000}, "R5");
    // R8: full-width passthrough
    run_vec(2'b00, 0, 32, {32'hDEAD_BEEF, 32'h0BAD_F00D}, '0, "R8");
    run_vec(2'b10, 0, 63, {32'hDEAD_BEEF, 32'h0BAD_F00D}, {32'hCAFE_F00D, 32'h1357_9BDF}, "R8");
    // R10: lanes with opposite data
    run_vec(2'b01, 4, 8, {32'h0000_0F00, 32'h0000_07F0}, '0, "R10");

    // Full sweep of opcode x offset x width
    for (int op = 0; op < 4; op++)
      for (int off = 0; off < 32; off++)
        for (int w = 0; w < 64; w++)
          run_vec(2'(op), off, w, {rnd(), rnd()}, {rnd(), rnd()},
                  tag_for(2'(op), off, w));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule